// File: doc/BRIEF.md
# Burst Access Window for a Timer Register Bank

This block sits on a simple register bus beside a bank of 32 timer registers. It lets a DMA engine move a run of consecutive registers through one fixed address, the window. A control register holds two fields. The first is a base register index. The second is a transfer count, encoded as count minus one. Each read or write at the window address is steered to the register at base plus the current burst index. The index then steps forward. After the last transfer of the burst it returns to zero.

Pacing uses a plain request/acknowledge pair. Writing the control register raises `dma_req`. The engine acknowledges, which drops the request. The engine then performs its window access, and that access raises the request again while transfers remain in the burst. Every bus access completes in one cycle with no back-pressure. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Bus addresses are byte addresses, and register i of the bank sits at byte address 4*i.

Top module: `dbr_window`

## Requirements
- R1: After reset, the control register reads 0x0000, `dma_req` is low, and every bank register reads 0.
- R2: The control register is at byte address 0x48. The count field is bits 12:8, the base field is bits 4:0, and all other bits read as zero.
- R3: A write at the window address (0x4C) stores its data in bank register (base + k) mod 32, where k is the current burst index.
- R4: A read at the window address returns bank register (base + k) mod 32 on `bus_rdata` one cycle after the read strobe.
- R5: A count field value N gives N+1 transfers. After the (N+1)-th window access the index is 0 again, so the next access targets the base register.
- R6: Count values above 17 are treated as 18 transfers.
- R7: Writing the control register resets the burst index to 0, including in the middle of a burst.
- R8: A control write raises `dma_req` in the next cycle, and `dma_ack` clears it in the next cycle. A window access sets `dma_req` high in the next cycle when transfers remain after it, and low after the last transfer.
- R9: Bank register i (i < 32, i not 18 or 19) is directly readable and writable at byte address 4*i. Addresses outside the bank read as 0, and writes to them have no effect.
- R10: The target index wraps modulo 32 when base + k exceeds 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, valid the cycle after `bus_rd` |
| dma_req | output | 1 | Transfer request to the DMA engine |
| dma_ack | input | 1 | Acknowledge from the DMA engine, clears `dma_req` |

## Verification
The bench builds the block with its defaults: a 32-entry bank, 16-bit data, 8-bit addresses, and an 18-transfer ceiling. With these values, a burst that starts at base 30 crosses the top of the bank. A full 18-transfer burst under a count of 31 shows the clamp against entry 18, which a 32-transfer burst would reach. Bank entries 18 and 19 are hidden behind the control and window addresses and can only be reached through the window.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int CNT_W  = 5;
  localparam int BASE_W = 5;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [BASE_W-1:0] base;
  } dbr_ctrl_t;

  function automatic logic [15:0] ctrl_pack(dbr_ctrl_t c);
    return {3'b000, c.cnt, 3'b000, c.base};
  endfunction

  function automatic dbr_ctrl_t ctrl_unpack(logic [15:0] w);
    dbr_ctrl_t c;
    c.cnt  = w[12:8];
    c.base = w[4:0];
    return c;
  endfunction
endpackage

// File: rtl/dbr_regbank.sv
module dbr_regbank #(
  parameter int NREG   = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq #(
  parameter int MAX_XFER = 18,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic             ack,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] idx,
  output logic             req
);
  localparam logic [CNT_W-1:0] LAST_MAX = CNT_W'(MAX_XFER - 1);

  logic [CNT_W-1:0] last;
  assign last = (cnt > LAST_MAX) ? LAST_MAX : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      req <= 1'b0;
    end else if (restart) begin
      idx <= '0;
      req <= 1'b1;
    end else if (step) begin
      if (idx == last) begin
        idx <= '0;
        req <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        req <= 1'b1;
      end
    end else if (ack) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/dbr_window.sv
module dbr_window
  import dbr_pkg::*;
#(
  parameter int              NREG     = 32,
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 8,
  parameter int              MAX_XFER = 18,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h48,
  parameter logic [ADDR_W-1:0] WIN_OFS  = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_req,
  input  logic              dma_ack
);
  localparam int IDX_W = $clog2(NREG);
  localparam int SPAN  = NREG * 4;

  logic      is_ctrl, is_win, dir_hit;
  logic      ctrl_wr, win_wr, win_acc, dir_wr;
  dbr_ctrl_t ctrl_q;
  logic [CNT_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  tgt_idx, dir_idx, rf_waddr, rf_raddr;
  logic [DATA_W-1:0] rf_rdata, rd_next;

  assign is_ctrl = (bus_addr == CTRL_OFS);
  assign is_win  = (bus_addr == WIN_OFS);
  assign dir_hit = (int'(bus_addr) < SPAN) && (bus_addr[1:0] == 2'b00)
                   && !is_ctrl && !is_win;
  assign dir_idx = bus_addr[IDX_W+1:2];

  assign ctrl_wr = bus_wr && is_ctrl;
  assign win_wr  = bus_wr && is_win;
  assign win_acc = (bus_wr || bus_rd) && is_win;
  assign dir_wr  = bus_wr && dir_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_unpack(16'(bus_wdata));
  end

  dbr_seq #(.MAX_XFER(MAX_XFER), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr),
    .step    (win_acc),
    .ack     (dma_ack),
    .cnt     (ctrl_q.cnt),
    .idx     (cur_idx),
    .req     (dma_req)
  );

  assign tgt_idx  = IDX_W'(ctrl_q.base) + IDX_W'(cur_idx);
  assign rf_waddr = win_wr ? tgt_idx : dir_idx;
  assign rf_raddr = is_win ? tgt_idx : dir_idx;

  dbr_regbank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (win_wr || dir_wr),
    .waddr (rf_waddr),
    .wdata (bus_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_comb begin
    if (is_ctrl)                rd_next = DATA_W'(ctrl_pack(ctrl_q));
    else if (is_win || dir_hit) rd_next = rf_rdata;
    else                        rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/dbr_window_chk.sv
module dbr_window_chk #(
  parameter int MAX_XFER = 18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic       win_acc,
  input logic       dma_ack,
  input logic       dma_req,
  input logic [4:0] idx,
  input logic [4:0] cnt
);
  localparam logic [4:0] LAST_MAX = 5'(MAX_XFER - 1);
  logic [4:0] last;
  assign last = (cnt > LAST_MAX) ? LAST_MAX : cnt;

  p_req_on_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> dma_req);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack && !ctrl_wr && !win_acc |=> !dma_req);

  p_idx_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> idx == 5'd0);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_acc && !ctrl_wr && idx != last |=> idx == $past(idx) + 5'd1 && dma_req);

  p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_acc && !ctrl_wr && idx == last |=> idx == 5'd0 && !dma_req);

  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx < 5'(MAX_XFER));
endmodule

bind dbr_window dbr_window_chk #(.MAX_XFER(MAX_XFER)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_wr (ctrl_wr),
  .win_acc (win_acc),
  .dma_ack (dma_ack),
  .dma_req (dma_req),
  .idx     (cur_idx),
  .cnt     (ctrl_q.cnt)
);

// File: tb/dbr_window_tb.sv
module dbr_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h48;
  localparam logic [7:0] A_WIN  = 8'h4C;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, dma_ack = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dma_req;
  int          n_chk = 0, n_err = 0;
  logic        done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_window u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .dma_ack(dma_ack)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic ack();
    dma_ack = 1;
    @(posedge clk); @(negedge clk);
    dma_ack = 0;
  endtask

  function automatic logic [15:0] ctl(int cnt, int base);
    return 16'((cnt << 8) | base);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    check("R1 req after reset", 16'(dma_req), 16'h0);
    rd(A_CTRL, d); check("R1 ctrl reset", d, 16'h0000);
    rd(8'h10, d);  check("R1 bank reset", d, 16'h0000);
  endtask

  task automatic t_fields();
    logic [15:0] d;
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, d); check("R2 reserved bits zero", d, 16'h1F1F);
    ack();
    check("R8 ack clears req", 16'(dma_req), 16'h0);
  endtask

  task automatic t_burst_write();
    logic [15:0] d;
    wr(A_CTRL, ctl(2, 3));
    check("R8 req after ctrl write", 16'(dma_req), 16'h1);
    for (int k = 0; k < 3; k++) begin
      ack();
      check("R8 req low after ack", 16'(dma_req), 16'h0);
      wr(A_WIN, 16'hA000 + 16'(k));
      check("R8 req after window access", 16'(dma_req), (k < 2) ? 16'h1 : 16'h0);
    end
    for (int k = 0; k < 3; k++) begin
      rd(8'(4 * (3 + k)), d);
      check("R3 window write target", d, 16'hA000 + 16'(k));
    end
    wr(A_WIN, 16'hB000);
    rd(8'h0C, d); check("R5 burst of N+1 wraps to base", d, 16'hB000);
    rd(8'h18, d); check("R5 entry after burst untouched", d, 16'h0000);
  endtask

  task automatic t_burst_read();
    logic [15:0] d;
    wr(8'h14, 16'h5555);
    wr(8'h18, 16'h6666);
    wr(A_CTRL, ctl(1, 5));
    rd(A_WIN, d); check("R4 window read k=0", d, 16'h5555);
    rd(A_WIN, d); check("R4 window read k=1", d, 16'h6666);
    rd(A_WIN, d); check("R5 read burst wraps", d, 16'h5555);
  endtask

  task automatic t_clamp();
    logic [15:0] d;
    wr(A_CTRL, ctl(31, 0));
    for (int k = 0; k < 18; k++) begin
      wr(A_WIN, 16'h0100 + 16'(k));
      if (k == 16) check("R6 req before last", 16'(dma_req), 16'h1);
    end
    check("R6 req low after 18th", 16'(dma_req), 16'h0);
    rd(A_WIN, d); check("R6 clamp to 18 transfers", d, 16'h0100);
    rd(8'h44, d); check("R6 17th entry written", d, 16'h0111);
  endtask

  task automatic t_midburst();
    logic [15:0] d;
    wr(A_CTRL, ctl(5, 8));
    wr(A_WIN, 16'hC000);
    wr(A_WIN, 16'hC001);
    wr(A_CTRL, ctl(5, 8));
    wr(A_WIN, 16'hC0FF);
    rd(8'h20, d); check("R7 index reset mid-burst", d, 16'hC0FF);
    rd(8'h24, d); check("R7 second entry kept", d, 16'hC001);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wr(A_CTRL, ctl(3, 30));
    for (int k = 0; k < 4; k++) wr(A_WIN, 16'hD000 + 16'(k));
    rd(8'h78, d); check("R10 entry 30", d, 16'hD000);
    rd(8'h7C, d); check("R10 entry 31", d, 16'hD001);
    rd(8'h00, d); check("R10 wrap to 0", d, 16'hD002);
    rd(8'h04, d); check("R10 wrap to 1", d, 16'hD003);
  endtask

  task automatic t_direct();
    logic [15:0] d;
    wr(8'h7C, 16'h1234);
    rd(8'h7C, d); check("R9 direct access", d, 16'h1234);
    wr(8'h90, 16'hBEEF);
    rd(8'h90, d); check("R9 unmapped reads zero", d, 16'h0000);
    rd(8'h7C, d); check("R9 unmapped write no effect", d, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_burst_write();
    t_burst_read();
    t_clamp();
    t_midburst();
    t_wrap();
    t_direct();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule